// File: doc/BRIEF.md
# Rewindable FIFO with Programmable Threshold Flags

This block is a single-clock first-in first-out buffer, 18 bits wide and 1024 words deep by default. It is meant for block transfers between two agents where a block may have to be sent again. Besides ordinary push and pop, the read side and the write side each keep a saved position. Pulsing a mark input stores the live pointer in that register. Pulsing a restore input moves the live pointer back to the stored position, so the consumer can read a block again or the producer can write it again.

Four status flags report occupancy: empty, almost-empty, almost-full and full. The two "almost" thresholds are offsets that are latched from input pins on a load strobe. Two protect modes guard a marked block. With read protection, full is judged against the saved read position, so unread-again data cannot be overwritten. With write protection, empty is judged against the saved write position, so a block still being written cannot be consumed. Skip pulses move either pointer forward by one word without moving any data.

The head word is always visible on the read-data port. A pop, or a read skip, retires the head word.

Top module: `rwnd_fifo`

## Requirements
- R1: While reset is asserted and right after it, all four pointers are 0. Empty and almost-empty are 1, almost-full and full are 0, and both offsets are 0.
- R2: Words leave in the order they entered. `rd_data` always shows the oldest stored word.
- R3: Let k be the stored count, n the almost-empty offset, m the almost-full offset and D the depth. Empty is (k==0). Almost-empty is (k<=n). Almost-full is (k>=D-m). Full is (k==D).
- R4: A cycle with `cfg_load`=1 latches `ae_off` as n and `af_off` as m. The flags use the new values after that clock edge. The offsets hold their values at all other times.
- R5: `mark_rd` copies the read pointer into the saved read position. `restore_rd` loads the read pointer from it, and in that cycle `restore_rd` takes priority over pop and read skip.
- R6: `mark_wr` copies the write pointer into the saved write position. `restore_wr` loads the write pointer from it. In that cycle it takes priority over push and write skip, and no word is written.
- R7: With `prot_rd`=1, full means write pointer minus saved read position equals D, instead of write pointer minus read pointer.
- R8: With `prot_wr`=1, empty means read pointer equals saved write position, instead of read pointer equals write pointer.
- R9: `rd_skip` advances the read pointer by one and `wr_skip` advances the write pointer by one. Neither pulse transfers data.
- R10: A pop or read skip while empty, and a push or write skip while full, is ignored. Pointers and stored words are left unchanged.
- R11: A push and a pop in the same cycle are both honoured when the FIFO is neither empty nor full. When empty, only the push takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push | input | 1 | Store `wr_data` at the write pointer |
| wr_data | input | 18 | Word to store |
| pop | input | 1 | Retire the head word |
| rd_data | output | 18 | Head word (oldest stored) |
| rd_skip | input | 1 | Advance read pointer by one without data |
| wr_skip | input | 1 | Advance write pointer by one without data |
| mark_rd | input | 1 | Save the read pointer |
| restore_rd | input | 1 | Load the read pointer from its saved copy |
| mark_wr | input | 1 | Save the write pointer |
| restore_wr | input | 1 | Load the write pointer from its saved copy |
| prot_rd | input | 1 | Full judged against saved read position |
| prot_wr | input | 1 | Empty judged against saved write position |
| cfg_load | input | 1 | Latch both offsets |
| ae_off | input | 10 | Almost-empty offset n |
| af_off | input | 10 | Almost-full offset m |
| empty | output | 1 | Empty flag |
| almost_empty | output | 1 | Almost-empty flag |
| almost_full | output | 1 | Almost-full flag |
| full | output | 1 | Full flag |

## Verification
Every pointer and offset is a register that updates on the rising edge where its command is sampled. The flags and `rd_data` are decoded from those registers with no further storage. A push, pop, skip, mark, restore or offset load is therefore visible in the cycle right after the edge that samples it. The protect-mode inputs act on the flags within the same cycle, with no edge at all. The bench drives every stimulus 2 ns after a rising edge and samples results 2 ns after the following edge. No check ever waits more than one edge, and no check reads the design's outputs at an edge.

// File: rtl/rwf_pkg.sv
package rwf_pkg;

    // action applied to a live pointer in one cycle
    typedef enum logic [1:0] {
        PA_HOLD = 2'd0,
        PA_STEP = 2'd1,
        PA_LOAD = 2'd2
    } ptr_act_t;

    typedef struct packed {
        logic empty;
        logic almost_empty;
        logic almost_full;
        logic full;
    } rwf_flags_t;

endpackage

// File: rtl/rwf_ptr_unit.sv
module rwf_ptr_unit #(
    parameter int PW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          load,
    input  logic          mark,
    output logic [PW-1:0] ptr,
    output logic [PW-1:0] saved
);
    import rwf_pkg::*;

    ptr_act_t act;

    always_comb begin
        if (load)      act = PA_LOAD;
        else if (step) act = PA_STEP;
        else           act = PA_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr   <= '0;
            saved <= '0;
        end else begin
            unique case (act)
                PA_LOAD: ptr <= saved;
                PA_STEP: ptr <= ptr + PW'(1);
                default: ptr <= ptr;
            endcase
            if (mark) saved <= ptr;
        end
    end
endmodule

// File: rtl/rwf_mem.sv
module rwf_mem #(
    parameter int W  = 18,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int D = 1 << AW;

    logic [W-1:0] store [D];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/rwf_flag_calc.sv
module rwf_flag_calc #(
    parameter int AW = 10
) (
    input  logic [AW:0]   rd_ptr,
    input  logic [AW:0]   wr_ptr,
    input  logic [AW:0]   rr_ptr,
    input  logic [AW:0]   rw_ptr,
    input  logic          prot_rd,
    input  logic          prot_wr,
    input  logic [AW-1:0] ae_n,
    input  logic [AW-1:0] af_m,
    output rwf_pkg::rwf_flags_t flags
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

    logic [PW-1:0] full_ref, empty_ref, lvl_full, lvl_empty, af_thr;

    always_comb begin
        full_ref  = prot_rd ? rr_ptr : rd_ptr;
        empty_ref = prot_wr ? rw_ptr : wr_ptr;
        lvl_full  = wr_ptr - full_ref;
        lvl_empty = empty_ref - rd_ptr;
        af_thr    = DEPTH_P - PW'(af_m);
        flags.empty        = (lvl_empty == '0);
        flags.almost_empty = (lvl_empty <= PW'(ae_n));
        flags.almost_full  = (lvl_full >= af_thr);
        flags.full         = (lvl_full == DEPTH_P);
    end
endmodule

// File: rtl/rwnd_fifo.sv
module rwnd_fifo #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic                     pop,
    output logic [WIDTH-1:0]         rd_data,
    input  logic                     rd_skip,
    input  logic                     wr_skip,
    input  logic                     mark_rd,
    input  logic                     restore_rd,
    input  logic                     mark_wr,
    input  logic                     restore_wr,
    input  logic                     prot_rd,
    input  logic                     prot_wr,
    input  logic                     cfg_load,
    input  logic [$clog2(DEPTH)-1:0] ae_off,
    input  logic [$clog2(DEPTH)-1:0] af_off,
    output logic                     empty,
    output logic                     almost_empty,
    output logic                     almost_full,
    output logic                     full
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0] rd_ptr, wr_ptr, rr_ptr, rw_ptr;
    logic [AW-1:0] ae_q, af_q;
    logic          rd_step, wr_step, mem_we;
    rwf_pkg::rwf_flags_t flags;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ae_q <= '0;
            af_q <= '0;
        end else if (cfg_load) begin
            ae_q <= ae_off;
            af_q <= af_off;
        end
    end

    assign rd_step = (pop || rd_skip) && !flags.empty;
    assign wr_step = (push || wr_skip) && !flags.full;
    assign mem_we  = push && !flags.full && !restore_wr;

    rwf_ptr_unit #(.PW(PW)) u_rd_side (
        .clk(clk), .rst_n(rst_n), .step(rd_step), .load(restore_rd),
        .mark(mark_rd), .ptr(rd_ptr), .saved(rr_ptr)
    );

    rwf_ptr_unit #(.PW(PW)) u_wr_side (
        .clk(clk), .rst_n(rst_n), .step(wr_step), .load(restore_wr),
        .mark(mark_wr), .ptr(wr_ptr), .saved(rw_ptr)
    );

    rwf_mem #(.W(WIDTH), .AW(AW)) u_mem (
        .clk(clk), .we(mem_we), .waddr(wr_ptr[AW-1:0]), .wdata(wr_data),
        .raddr(rd_ptr[AW-1:0]), .rdata(rd_data)
    );

    rwf_flag_calc #(.AW(AW)) u_flags (
        .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .rr_ptr(rr_ptr), .rw_ptr(rw_ptr),
        .prot_rd(prot_rd), .prot_wr(prot_wr), .ae_n(ae_q), .af_m(af_q),
        .flags(flags)
    );

    assign empty        = flags.empty;
    assign almost_empty = flags.almost_empty;
    assign almost_full  = flags.almost_full;
    assign full         = flags.full;
endmodule

// File: rtl/rwnd_fifo_chk.sv
module rwnd_fifo_chk (
    input logic clk,
    input logic rst_n,
    input logic push,
    input logic pop,
    input logic rd_skip,
    input logic wr_skip,
    input logic mark_rd,
    input logic mark_wr,
    input logic restore_rd,
    input logic restore_wr,
    input logic prot_rd,
    input logic prot_wr,
    input logic empty,
    input logic almost_empty,
    input logic almost_full,
    input logic full
);
    AST_RESET_FLAGS: assert property (@(posedge clk) !rst_n |-> (empty && almost_empty && !almost_full && !full)); // R1
    AST_EMPTY_IN_AE: assert property (@(posedge clk) disable iff (!rst_n) empty |-> almost_empty); // R3
    AST_FULL_IN_AF: assert property (@(posedge clk) disable iff (!rst_n) full |-> almost_full); // R3
    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n) (!prot_rd && !prot_wr) |-> !(empty && full)); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(full && push && !pop && !rd_skip && !restore_rd && !restore_wr && !mark_rd) && $stable(prot_rd)) |-> full); // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(empty && pop && !push && !wr_skip && !restore_rd && !restore_wr && !mark_wr) && $stable(prot_wr)) |-> empty); // R10
endmodule

bind rwnd_fifo rwnd_fifo_chk chk_i (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .rd_skip(rd_skip),
    .wr_skip(wr_skip), .mark_rd(mark_rd), .mark_wr(mark_wr),
    .restore_rd(restore_rd), .restore_wr(restore_wr), .prot_rd(prot_rd),
    .prot_wr(prot_wr), .empty(empty), .almost_empty(almost_empty),
    .almost_full(almost_full), .full(full)
);

// File: tb/rwnd_fifo_tb_top.sv
module rwnd_fifo_tb_top;
    localparam int W = 18;
    localparam int D = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push = 0, pop = 0, rd_skip = 0, wr_skip = 0;
    logic mark_rd = 0, restore_rd = 0, mark_wr = 0, restore_wr = 0;
    logic prot_rd = 0, prot_wr = 0, cfg_load = 0;
    logic [W-1:0] wr_data = '0;
    logic [9:0] ae_off = '0, af_off = '0;
    logic [W-1:0] rd_data;
    logic empty, almost_empty, almost_full, full;
    int checks = 0, failures = 0;

    always #5 clk = ~clk;

    rwnd_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .push(push), .wr_data(wr_data), .pop(pop),
        .rd_data(rd_data), .rd_skip(rd_skip), .wr_skip(wr_skip),
        .mark_rd(mark_rd), .restore_rd(restore_rd), .mark_wr(mark_wr),
        .restore_wr(restore_wr), .prot_rd(prot_rd), .prot_wr(prot_wr),
        .cfg_load(cfg_load), .ae_off(ae_off), .af_off(af_off),
        .empty(empty), .almost_empty(almost_empty),
        .almost_full(almost_full), .full(full)
    );

    typedef struct packed {
        logic         push;
        logic         pop;
        logic [17:0]  din;
        logic [3:0]   flg;   // {empty, almost_empty, almost_full, full}
        logic [17:0]  head;  // checked when not empty
    } vec_t;

    // offsets n=2, m=3 are loaded before this table is walked
    localparam vec_t VEC [11] = '{
        '{1'b1, 1'b0, 18'h01001, 4'b0100, 18'h01001},  // R3 count 1
        '{1'b1, 1'b0, 18'h01002, 4'b0100, 18'h01001},  // R3 count 2
        '{1'b1, 1'b0, 18'h01003, 4'b0000, 18'h01001},  // R3 count 3
        '{1'b1, 1'b1, 18'h01004, 4'b0000, 18'h01002},  // R11 push+pop
        '{1'b0, 1'b1, 18'h00000, 4'b0100, 18'h01003},  // R2 order
        '{1'b0, 1'b1, 18'h00000, 4'b0100, 18'h01004},  // R2 order
        '{1'b0, 1'b1, 18'h00000, 4'b1100, 18'h00000},  // R3 empty
        '{1'b0, 1'b1, 18'h00000, 4'b1100, 18'h00000},  // R10 pop on empty
        '{1'b1, 1'b0, 18'h01005, 4'b0100, 18'h01005},  // R2
        '{1'b0, 1'b1, 18'h00000, 4'b1100, 18'h00000},  // R3
        '{1'b1, 1'b1, 18'h01006, 4'b0100, 18'h01006}   // R11 push+pop on empty
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] flg();
        return {28'd0, empty, almost_empty, almost_full, full};
    endfunction

    task automatic tick();
        @(posedge clk);
        #2;
        push = 0; pop = 0; rd_skip = 0; wr_skip = 0;
        mark_rd = 0; restore_rd = 0; mark_wr = 0; restore_wr = 0; cfg_load = 0;
    endtask

    task automatic do_push(input logic [W-1:0] d);
        push = 1; wr_data = d; tick();
    endtask

    task automatic do_pop();
        pop = 1; tick();
    endtask

    task automatic do_reset();
        prot_rd = 0; prot_wr = 0;
        rst_n = 0;
        repeat (2) @(posedge clk);
        #2 rst_n = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1 flags after reset", flg(), 32'b1100);
        // R4: offsets are 0 after reset, so one word already clears almost-empty
        do_push(18'h00AAA);
        chk("R4 zero offset", flg(), 32'b0000);
        chk("R2 head", rd_data, 18'h00AAA);
        do_pop();
        chk("R1 back to empty", flg(), 32'b1100);

        ae_off = 10'd2; af_off = 10'd3; cfg_load = 1; tick();
        for (int i = 0; i < 11; i++) begin
            push = VEC[i].push; pop = VEC[i].pop; wr_data = VEC[i].din;
            tick();
            chk("R3 table flags", flg(), {28'd0, VEC[i].flg});
            if (!VEC[i].flg[3]) chk("R2 table head", rd_data, VEC[i].head);
        end
        do_pop();

        // fill to full with n=2, m=3: almost-full from 1021 words
        for (int c = 1; c <= D; c++) begin
            do_push(18'(c - 1));
            if (c == 1020) chk("R3 below AF", flg(), 32'b0000);
            if (c == 1021) chk("R3 AF edge", flg(), 32'b0010);
            if (c == 1023) chk("R3 AF only", flg(), 32'b0010);
            if (c == 1024) chk("R3 full", flg(), 32'b0011);
        end
        do_push(18'h3FFFF);
        chk("R10 push on full", flg(), 32'b0011);
        wr_skip = 1; tick();
        chk("R10 skip on full", flg(), 32'b0011);
        for (int c = 0; c < D; c++) begin
            chk("R2 drain order", rd_data, 18'(c));
            do_pop();
            if (c == 0) chk("R3 leaves full", flg(), 32'b0010);
        end
        chk("R3 drained", flg(), 32'b1100);

        // R5 reread
        do_reset();
        mark_rd = 1; tick();
        for (int i = 0; i < 4; i++) do_push(18'h02000 + 18'(i));
        do_pop(); do_pop();
        chk("R5 head before restore", rd_data, 18'h02002);
        restore_rd = 1; pop = 1; tick();
        chk("R5 head after restore", rd_data, 18'h02000);
        for (int i = 0; i < 4; i++) begin
            chk("R5 reread order", rd_data, 18'h02000 + 18'(i));
            do_pop();
        end
        chk("R5 empty after reread", flg(), 32'b1100);

        // R7 read protection
        do_reset();
        mark_rd = 1; tick();
        for (int i = 0; i < 10; i++) do_push(18'h0);
        for (int i = 0; i < 10; i++) do_pop();
        prot_rd = 1;
        for (int i = 0; i < 1013; i++) do_push(18'h1);
        chk("R7 not yet full", {31'd0, full}, 32'd0);
        do_push(18'h1);
        chk("R7 full at saved read pos", {31'd0, full}, 32'd1);
        prot_rd = 0; #1;
        chk("R7 normal full released", {31'd0, full}, 32'd0);

        // R8 write protection and R6 rewrite
        do_reset();
        for (int i = 0; i < 3; i++) do_push(18'h04000 + 18'(i));
        mark_wr = 1; tick();
        do_push(18'h04003); do_push(18'h04004);
        prot_wr = 1;
        do_pop(); do_pop();
        chk("R8 not empty yet", {31'd0, empty}, 32'd0);
        do_pop();
        chk("R8 empty at saved write pos", {31'd0, empty}, 32'd1);
        do_pop();
        chk("R10 pop blocked by protect", {31'd0, empty}, 32'd1);
        prot_wr = 0; #1;
        chk("R8 normal empty released", {31'd0, empty}, 32'd0);
        chk("R8 word kept", rd_data, 18'h04003);
        restore_wr = 1; push = 1; wr_data = 18'h3AAAA; tick();
        chk("R6 write ptr restored", {31'd0, empty}, 32'd1);
        do_push(18'h05555);
        chk("R6 rewritten head", rd_data, 18'h05555);

        // R9 skip pulses
        do_reset();
        for (int i = 0; i < 3; i++) do_push(18'h03000 + 18'(i));
        rd_skip = 1; tick();
        chk("R9 read skip head", rd_data, 18'h03001);
        wr_skip = 1; tick();
        do_pop();
        chk("R9 head after pop", rd_data, 18'h03002);
        do_pop();
        chk("R9 skipped slot counted", {31'd0, empty}, 32'd0);
        do_pop();
        chk("R9 empty", {31'd0, empty}, 32'd1);
        rd_skip = 1; tick();
        do_push(18'h03ABC);
        chk("R10 skip on empty ignored", rd_data, 18'h03ABC);
        chk("R10 one word", flg(), 32'b0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule